// File: doc/BRIEF.md
# Bus Hang Watchdog

This block guards a processor bus against accesses that never complete. It does not decode addresses. It watches every bus cycle by timing how long the data-enable strobe stays asserted. When the strobe is held longer than a programmable timeout, the watchdog can finish the stalled access on behalf of the silent target, and it can flag the event on a bus-error line.

Forced ready and bus error have separate enable bits, so the block can do either, both or neither. The bus-error line has two modes:
- In pulse mode it produces a fixed-length pulse. This suits an edge-sensitive receiver.
- In level mode it latches high until software reads the timeout register. This suits a level-sensitive receiver.

A timeout value of zero turns detection off. Every output is low after reset.

Top module: `bus_hang_watchdog`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `rdy_o` and `berr_o` are low.
- R2: With a non-zero timeout T, a timeout is declared on the (T+1)-th consecutive rising clock edge that samples the strobe active. If `rdy_en` is 1, `rdy_o` is high for exactly the one clock that follows that edge.
- R3: If `rdy_en` is 0, a timeout never raises `rdy_o`.
- R4: If `err_en` is 0, a timeout never raises `berr_o`.
- R5: In pulse mode (`err_level` = 0), `berr_o` is high for exactly PULSE_CYC clocks (2 by default), starting on the clock after the timeout edge.
- R6: In level mode (`err_level` = 1), `berr_o` goes high on the clock after the timeout edge. It stays high, even after the strobe drops, until an edge samples `tmo_rd` high, and it is low from the next clock.
- R7: In pulse mode, `tmo_rd` does not shorten the error pulse.
- R8: A clock edge that samples the strobe inactive restarts the count. Held runs that are each no longer than T edges never cause a timeout.
- R9: At most one timeout is declared per continuous assertion of the strobe, however long it lasts.
- R10: A timeout value of 0 disables detection: neither output rises.
- R11: The largest timeout value, 2^TMO_W-1 (31 by default), fires on edge 2^TMO_W (32).
- R12: Ready generation and error generation act independently. Error reporting works with `rdy_en` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| den | input | 1 | Data-enable strobe of the bus cycle; active high unless DEN_ACTIVE_LOW is set |
| rdy_en | input | 1 | 1 = drive ready on timeout |
| err_en | input | 1 | 1 = drive bus error on timeout |
| err_level | input | 1 | 0 = pulse mode, 1 = latched level mode |
| tmo_val | input | TMO_W | Timeout in clocks; 0 disables detection |
| tmo_rd | input | 1 | Read strobe of the timeout register; clears a latched error |
| rdy_o | output | 1 | One-clock forced ready, active high |
| berr_o | output | 1 | Bus error, active high |

## Verification
The bench builds the block with TMO_W = 5, PULSE_CYC = 2 and an active-high strobe. With these values the maximum timeout of 31 and the saturation of the counter at its top value are reached within a few dozen clocks, so the same directed tasks cover the smallest, typical and largest timeouts. The two-clock pulse allows a read strobe to be placed inside the pulse, which shows that a read does not shorten it. Level mode is checked across the strobe dropping, which shows that only the read clears the latched error.

// File: rtl/bhw_pkg.sv
package bhw_pkg;

   typedef enum logic {
      ERR_PULSE = 1'b0,
      ERR_LEVEL = 1'b1
   } err_mode_e;

   localparam int unsigned MAX_TMO_W = 16;

endpackage

// File: rtl/bhw_timer.sv
module bhw_timer #(
   parameter int unsigned TMO_W          = 5,
   parameter bit          DEN_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             den_raw,
   input  logic [TMO_W-1:0] tmo_val,
   output logic             fire
);

   localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

   logic             den_act;
   logic [TMO_W-1:0] cnt;
   logic             fired;

   // strobe polarity variant
   generate
      if (DEN_ACTIVE_LOW) begin : g_low
         assign den_act = ~den_raw;
      end else begin : g_high
         assign den_act = den_raw;
      end
   endgenerate

   // cnt holds the number of earlier consecutive edges that saw the strobe active
   assign fire = den_act && (tmo_val != '0) && (cnt == tmo_val) && !fired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         fired <= 1'b0;
      end else if (!den_act) begin
         cnt   <= '0;
         fired <= 1'b0;
      end else begin
         if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
         if (fire)           fired <= 1'b1;
      end
   end

endmodule

// File: rtl/bhw_ready.sv
module bhw_ready (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic rdy_en,
   output logic rdy_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy_o <= 1'b0;
      else        rdy_o <= fire & rdy_en;
   end

endmodule

// File: rtl/bhw_err.sv
module bhw_err
   import bhw_pkg::*;
#(
   parameter int unsigned PULSE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic err_en,
   input  logic err_level,
   input  logic tmo_rd,
   output logic berr_o
);

   err_mode_e mode;
   logic      hit_pulse;
   logic      hit_level;
   logic      pulse_on;
   logic      level_q;

   assign mode      = err_mode_e'(err_level);
   assign hit_pulse = fire & err_en & (mode == ERR_PULSE);
   assign hit_level = fire & err_en & (mode == ERR_LEVEL);

   // pulse stretcher variant: a single flop or a down-counter
   generate
      if (PULSE_CYC == 1) begin : g_one
         logic p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) p_q <= 1'b0;
            else        p_q <= hit_pulse;
         end
         assign pulse_on = p_q;
      end else begin : g_cnt
         localparam int unsigned     PCNT_W = $clog2(PULSE_CYC + 1);
         localparam logic [PCNT_W-1:0] PLOAD = PCNT_W'(PULSE_CYC);
         logic [PCNT_W-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              pcnt <= '0;
            else if (hit_pulse)      pcnt <= PLOAD;
            else if (pcnt != '0)     pcnt <= pcnt - 1'b1;
         end
         assign pulse_on = (pcnt != '0);
      end
   endgenerate

   // latched level: a new timeout wins over a read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         level_q <= 1'b0;
      else if (hit_level) level_q <= 1'b1;
      else if (tmo_rd)    level_q <= 1'b0;
   end

   assign berr_o = pulse_on | level_q;

endmodule

// File: rtl/bus_hang_watchdog.sv
module bus_hang_watchdog
   import bhw_pkg::*;
#(
   parameter int unsigned TMO_W          = 5,
   parameter int unsigned PULSE_CYC      = 2,
   parameter bit          DEN_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             den,
   input  logic             rdy_en,
   input  logic             err_en,
   input  logic             err_level,
   input  logic [TMO_W-1:0] tmo_val,
   input  logic             tmo_rd,
   output logic             rdy_o,
   output logic             berr_o
);

   // elaboration-time parameter checks
   generate
      if (TMO_W < 1 || TMO_W > MAX_TMO_W) begin : g_bad_tmo_w
         $error("bus_hang_watchdog: TMO_W out of range");
      end
      if (PULSE_CYC < 1 || PULSE_CYC > 64) begin : g_bad_pulse
         $error("bus_hang_watchdog: PULSE_CYC out of range");
      end
   endgenerate

   logic fire;

   bhw_timer #(
      .TMO_W          (TMO_W),
      .DEN_ACTIVE_LOW (DEN_ACTIVE_LOW)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .den_raw (den),
      .tmo_val (tmo_val),
      .fire    (fire)
   );

   bhw_ready i_ready (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .rdy_en (rdy_en),
      .rdy_o  (rdy_o)
   );

   bhw_err #(
      .PULSE_CYC (PULSE_CYC)
   ) i_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .err_en    (err_en),
      .err_level (err_level),
      .tmo_rd    (tmo_rd),
      .berr_o    (berr_o)
   );

endmodule

// File: rtl/bhw_checker.sv
module bhw_checker #(
   parameter int unsigned TMO_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             den,
   input logic             rdy_en,
   input logic             err_en,
   input logic             err_level,
   input logic [TMO_W-1:0] tmo_val,
   input logic             tmo_rd,
   input logic             rdy_o,
   input logic             berr_o
);

   // R2: forced ready lasts one clock
   a_r2_rdy_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_o |=> !rdy_o);

   // R3: ready only with ready-enable set
   a_r3_rdy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_o |-> $past(rdy_en));

   // R4: error only with error-enable set
   a_r4_berr_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(berr_o) |-> $past(err_en));

   // R5: pulse mode gives exactly two clocks
   a_r5_pulse_two: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(berr_o) && $past(!err_level)) |=> (berr_o ##1 !berr_o));

   // R6: level mode holds until a read
   a_r6_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(berr_o) && $past(err_level) && !tmo_rd) |=> berr_o);

   // R10: zero timeout never forces ready
   a_r10_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_o |-> $past(tmo_val != '0));

endmodule

bind bus_hang_watchdog bhw_checker #(.TMO_W(TMO_W)) i_bhw_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .den       (den),
   .rdy_en    (rdy_en),
   .err_en    (err_en),
   .err_level (err_level),
   .tmo_val   (tmo_val),
   .tmo_rd    (tmo_rd),
   .rdy_o     (rdy_o),
   .berr_o    (berr_o)
);

// File: tb/test_bus_hang_watchdog.sv
module test_bus_hang_watchdog;

   localparam int TMO_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             den = 1'b0;
   logic             rdy_en = 1'b0;
   logic             err_en = 1'b0;
   logic             err_level = 1'b0;
   logic [TMO_W-1:0] tmo_val = '0;
   logic             tmo_rd = 1'b0;
   logic             rdy_o;
   logic             berr_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   bus_hang_watchdog #(.TMO_W(TMO_W), .PULSE_CYC(2), .DEN_ACTIVE_LOW(1'b0)) i_bus_hang_watchdog (
      .clk(clk), .rst_n(rst_n), .den(den), .rdy_en(rdy_en), .err_en(err_en),
      .err_level(err_level), .tmo_val(tmo_val), .tmo_rd(tmo_rd),
      .rdy_o(rdy_o), .berr_o(berr_o));

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   // hold strobe for n edges starting at a negedge; checks every cycle
   task automatic run_hold(input string req, input int t, input int n, input bit exp_fire);
      den = 1'b1;
      for (int k = 1; k <= n; k++) begin
         logic er, eb;
         @(posedge clk); @(negedge clk);
         er = exp_fire && rdy_en && (k == t + 1);
         if (!err_level) eb = exp_fire && err_en && ((k == t + 1) || (k == t + 2));
         else            eb = exp_fire && err_en && (k >= t + 1);
         chk(req, "rdy_o", rdy_o, er);
         chk(req, "berr_o", berr_o, eb);
      end
      den = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic t_reset;
      #2;
      chk("R1", "rdy_o in reset", rdy_o, 1'b0);
      chk("R1", "berr_o in reset", berr_o, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R1", "rdy_o after reset", rdy_o, 1'b0);
      chk("R1", "berr_o after reset", berr_o, 1'b0);
   endtask

   task automatic t_basic;   // R2 R5 R9
      rdy_en = 1; err_en = 1; err_level = 0; tmo_val = 5'd3;
      run_hold("R2/R5/R9", 3, 10, 1'b1);
      idle(3);
   endtask

   task automatic t_no_ready;  // R3 R12
      rdy_en = 0; err_en = 1; err_level = 0; tmo_val = 5'd4;
      run_hold("R3/R12", 4, 8, 1'b1);
      idle(3);
   endtask

   task automatic t_no_err;  // R4
      rdy_en = 1; err_en = 0; err_level = 0; tmo_val = 5'd2;
      run_hold("R4", 2, 6, 1'b1);
      idle(3);
   endtask

   task automatic t_level;  // R6
      rdy_en = 1; err_en = 1; err_level = 1; tmo_val = 5'd2;
      run_hold("R6", 2, 5, 1'b1);
      idle(4);
      chk("R6", "berr_o held after strobe drop", berr_o, 1'b1);
      tmo_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      tmo_rd = 1'b0;
      chk("R6", "berr_o cleared by read", berr_o, 1'b0);
      idle(2);
      chk("R6", "berr_o stays clear", berr_o, 1'b0);
      err_level = 0;
   endtask

   task automatic t_read_pulse;  // R7
      rdy_en = 1; err_en = 1; err_level = 0; tmo_val = 5'd2;
      run_hold("R7", 2, 3, 1'b1);
      tmo_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      tmo_rd = 1'b0;
      chk("R7", "pulse second clock despite read", berr_o, 1'b1);
      @(posedge clk); @(negedge clk);
      chk("R7", "pulse ended", berr_o, 1'b0);
      idle(2);
   endtask

   task automatic t_restart;  // R8
      rdy_en = 1; err_en = 1; err_level = 0; tmo_val = 5'd5;
      run_hold("R8", 5, 5, 1'b0);
      idle(1);
      run_hold("R8", 5, 5, 1'b0);
      idle(1);
      run_hold("R8", 5, 4, 1'b0);
      idle(2);
   endtask

   task automatic t_zero;  // R10
      rdy_en = 1; err_en = 1; err_level = 0; tmo_val = 5'd0;
      run_hold("R10", 0, 40, 1'b0);
      idle(3);
   endtask

   task automatic t_max;  // R11
      rdy_en = 1; err_en = 1; err_level = 0; tmo_val = 5'd31;
      run_hold("R11", 31, 36, 1'b1);
      idle(3);
   endtask

   initial begin
      #(8 * 50000);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_no_ready();
      t_no_err();
      t_level();
      t_read_pulse();
      t_restart();
      t_zero();
      t_max();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule